// File: doc/BRIEF.md
# Burst Flash Word Stager

This block collects up to four 32-bit words from the CPU and then writes them into flash as a short burst, one word at a time, at consecutive word addresses. Each word has its own slot register and a pending bit. The bit rises when the CPU writes the slot and drops on its own once the flash port accepts that word. The CPU starts a burst by giving a start address and the index of the last slot to send. A sequencer then walks the slots from slot 0 upward.

The flash side is a plain request/acknowledge handshake. The sequencer raises a request for the current slot only while that slot's pending bit is set, so a burst can begin before all words are written and waits for slow software. An error response ends the burst early. The status outputs are a busy bit, a sticky fail bit, the pending vector and the live word address. After a burst ends, normally or by error, the address output keeps the last address that was worked on.

Register writes and reads use a small select code. Codes 0 to 3 name slots 0 to 3. Code 4 is an alias of slot 0, kept for code that uses the older single-word data register.

Top module: `burst_prog_stager`

## Requirements
- R1: After reset, busy, fail, the pending vector, the live address, flashReq and every slot value read back as 0.
- R2: A write with select code k (0 to 3) stores the data in slot k and sets pending bit k on the next clock edge. A read with select code k returns that slot's data.
- R3: Select code 4 is an alias of slot 0. A write with code 4 updates slot 0 and sets pending bit 0. A read with code 4 returns slot 0.
- R4: A start pulse while idle sets busy on the next edge. It loads the live address with startAddr, with bits [1:0] forced to 00. The live address always has bits [1:0] equal to 00.
- R5: While busy and the current slot's pending bit is set, flashReq is 1, flashAddr equals the live address and flashData equals the current slot's data. These hold steady until an acknowledge or an error arrives.
- R6: An acknowledge clears the current slot's pending bit on that edge. If the slot is not the last one, the live address advances by 4 and the next slot becomes current.
- R7: If the current slot's pending bit is clear, flashReq stays 0 and busy stays 1 until the slot is written. The request then rises in the cycle after that write.
- R8: An acknowledge of the last slot (slot index startLen) drops busy. The live address keeps the final programmed address and does not advance.
- R9: An error response (flashErr with flashReq) sets fail and drops busy on that edge. The pending bits of the slot under request and of all later slots stay set. The live address keeps the address of the failed word.
- R10: Writing a slot whose pending bit is already set replaces its data and leaves the bit set.
- R11: A start while idle clears fail. A start while busy is ignored: busy, the live address and the current slot are unchanged.
- R12: If the CPU writes the slot under request in the same cycle that the slot is acknowledged, the write wins. The new data is stored and the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Write select code (0-3 slot, 4 alias of slot 0) |
| regWrData | input | 32 | Write data |
| regRdSel | input | 3 | Read select code, same encoding as the write select |
| regRdData | output | 32 | Read data; 0 for unused codes |
| start | input | 1 | One-cycle burst start pulse |
| startAddr | input | 32 | Flash byte address of the first word |
| startLen | input | 2 | Index of the last slot in the burst |
| flashReq | output | 1 | Word program request |
| flashAddr | output | 32 | Word address of the request |
| flashData | output | 32 | Data of the request |
| flashAck | input | 1 | Word accepted by flash |
| flashErr | input | 1 | Word rejected; aborts the burst |
| busy | output | 1 | Burst in progress |
| fail | output | 1 | Last burst ended on an error |
| pending | output | 4 | Per-slot pending bits |
| curAddr | output | 32 | Live word address, held after the burst |

## Verification
Slot writes, starts, acknowledges and errors are all registered, so their effects on the pending bits, busy, fail and the live address appear one clock edge after the stimulus. The request, address and data toward flash are combinational on that state and follow in the same cycle. The bench drives every input on the falling edge and samples on the next falling edge, which is exactly one rising edge later. For the stall case it samples the request on several consecutive falling edges, and it checks it again one cycle after the late slot write.

// File: rtl/burst_prog_pkg.sv
package burst_prog_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAddr;  // load live address from start address
    logic incAddr;   // step live address to next word
    logic retire;    // current slot accepted by flash
  } seqStrobe_t;

endpackage

// File: rtl/burst_prog_datapath.sv
module burst_prog_datapath
  import burst_prog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] startAddr,
  input  seqStrobe_t        strb,
  input  logic [IDX_W-1:0]  slotIdx,
  output logic [SLOTS-1:0]  pending,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] slotData
);

  localparam logic [SEL_W-1:0]  ALIAS_SEL = SEL_W'(SLOTS);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic [DATA_W-1:0] slotReg [SLOTS];
  logic [SLOTS-1:0]  hit;

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    if (g == 0) begin : gAlias
      assign hit[g] = wrEn && (wrSel == SEL_W'(g) || wrSel == ALIAS_SEL);
    end else begin : gPlain
      assign hit[g] = wrEn && (wrSel == SEL_W'(g));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotReg[g] <= '0;
        pending[g] <= 1'b0;
      end else if (hit[g]) begin
        slotReg[g] <= wrData;
        pending[g] <= 1'b1;
      end else if (strb.retire && slotIdx == IDX_W'(g)) begin
        pending[g] <= 1'b0;
      end
    end

    // R2 / R10 / R12: a CPU write always leaves the flag set
    assert_write_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
      hit[g] |=> pending[g]);

    // R6: an accepted word with no competing write clears its flag
    assert_retire_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.retire && slotIdx == IDX_W'(g) && !hit[g]) |=> !pending[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strb.loadAddr) begin
      curAddr <= {startAddr[ADDR_W-1:2], 2'b00};
    end else if (strb.incAddr) begin
      curAddr <= curAddr + WORD_STEP;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rdSel == SEL_W'(i)) rdData = slotReg[i];
    end
    if (rdSel == ALIAS_SEL) rdData = slotReg[0];
  end

  assign slotData = slotReg[slotIdx];

  // R4: live address is always word aligned
  assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    curAddr[1:0] == 2'b00);

endmodule

// File: rtl/burst_prog_ctrl.sv
module burst_prog_ctrl
  import burst_prog_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] startLen,
  input  logic [SLOTS-1:0] pending,
  input  logic             flashAck,
  input  logic             flashErr,
  output logic             busy,
  output logic             fail,
  output logic [IDX_W-1:0] slotIdx,
  output logic             flashReq,
  output seqStrobe_t       strb
);

  logic [IDX_W-1:0] lastIdx;
  logic take, accept, abort, atLast;

  assign flashReq = busy && pending[slotIdx];
  assign take     = start && !busy;
  assign abort    = flashReq && flashErr;
  assign accept   = flashReq && flashAck && !flashErr;
  assign atLast   = (slotIdx == lastIdx);

  always_comb begin
    strb          = '0;
    strb.loadAddr = take;
    strb.incAddr  = accept && !atLast;
    strb.retire   = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      fail    <= 1'b0;
      slotIdx <= '0;
      lastIdx <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      fail    <= 1'b0;
      slotIdx <= '0;
      lastIdx <= startLen;
    end else if (abort) begin
      busy <= 1'b0;
      fail <= 1'b1;
    end else if (accept) begin
      if (atLast) busy <= 1'b0;
      else        slotIdx <= slotIdx + 1'b1;
    end
  end

  // R9: an error response ends the burst and flags failure
  assert_abort_fails_R9: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (fail && !busy));

  // R8: acceptance of the last slot ends the burst cleanly
  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && atLast) |=> (!busy && !fail));

  // R11: a start while busy changes nothing in the sequence
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !flashReq) |=> (busy && $stable(slotIdx)));

  // R7: no request is raised for an empty slot
  assert_stall_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pending[slotIdx]) |-> !flashReq);

endmodule

// File: rtl/burst_prog_stager.sv
module burst_prog_stager
  import burst_prog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned SEL_W = $clog2(SLOTS + 1),
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [SEL_W-1:0]  regRdSel,
  output logic [DATA_W-1:0] regRdData,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [IDX_W-1:0]  startLen,
  output logic              flashReq,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashData,
  input  logic              flashAck,
  input  logic              flashErr,
  output logic              busy,
  output logic              fail,
  output logic [SLOTS-1:0]  pending,
  output logic [ADDR_W-1:0] curAddr
);

  seqStrobe_t       strb;
  logic [IDX_W-1:0] slotIdx;

  burst_prog_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .startLen (startLen),
    .pending  (pending),
    .flashAck (flashAck),
    .flashErr (flashErr),
    .busy     (busy),
    .fail     (fail),
    .slotIdx  (slotIdx),
    .flashReq (flashReq),
    .strb     (strb)
  );

  burst_prog_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS),
    .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .wrSel     (regWrSel),
    .wrData    (regWrData),
    .rdSel     (regRdSel),
    .rdData    (regRdData),
    .startAddr (startAddr),
    .strb      (strb),
    .slotIdx   (slotIdx),
    .pending   (pending),
    .curAddr   (curAddr),
    .slotData  (flashData)
  );

  assign flashAddr = curAddr;

  // R5: an open request keeps its address until answered
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && !flashAck && !flashErr && !regWrEn) |=> (flashReq && $stable(flashAddr)));

endmodule

// File: tb/sim_burst_prog_stager.sv
`timescale 1ns/1ps
module sim_burst_prog_stager;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdSel = '0;
  logic [31:0] regRdData;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic [1:0]  startLen = '0;
  logic        flashReq;
  logic [31:0] flashAddr, flashData;
  logic        flashAck = 1'b0;
  logic        flashErr = 1'b0;
  logic        busy, fail;
  logic [3:0]  pending;
  logic [31:0] curAddr;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  burst_prog_stager u0 (.*);

  typedef struct packed {
    logic [2:0]  sel;
    logic [31:0] data;
    logic [2:0]  rdSel;
    logic [31:0] expRd;
    logic [3:0]  expPend;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t TBL [NVEC] = '{
    '{3'd1, 32'h1111_1111, 3'd1, 32'h1111_1111, 4'b0010},  // R2
    '{3'd0, 32'h2222_0000, 3'd0, 32'h2222_0000, 4'b0011},  // R2
    '{3'd4, 32'h3333_4444, 3'd0, 32'h3333_4444, 4'b0011},  // R3 alias write
    '{3'd3, 32'h5555_6666, 3'd3, 32'h5555_6666, 4'b1011},  // R2
    '{3'd1, 32'h7777_8888, 3'd1, 32'h7777_8888, 4'b1011},  // R10 overwrite
    '{3'd2, 32'h9999_AAAA, 3'd4, 32'h3333_4444, 4'b1111}   // R3 alias read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [2:0] sel, input logic [31:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic startOp(input logic [31:0] addr, input logic [1:0] len);
    start = 1'b1; startAddr = addr; startLen = len;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic readSel(input logic [2:0] sel, output logic [31:0] val);
    regRdSel = sel;
    #1 val = regRdData;
  endtask

  task automatic serve(input logic [31:0] eAddr, input logic [31:0] eData,
                       input logic err, input string tag);
    int n = 0;
    while (!flashReq && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " req"}, {31'd0, flashReq}, 32'd1);
    chk({tag, " addr"}, flashAddr, eAddr);
    chk({tag, " data"}, flashData, eData);
    flashAck = !err; flashErr = err;
    @(negedge clk);
    flashAck = 1'b0; flashErr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 fail", {31'd0, fail}, 32'd0);
    chk("R1 pending", {28'd0, pending}, 32'd0);
    chk("R1 curAddr", curAddr, 32'd0);
    chk("R1 req", {31'd0, flashReq}, 32'd0);
    readSel(3'd2, rv);
    chk("R1 slot", rv, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table: slot writes, alias and overwrite (R2 R3 R10)
    for (int i = 0; i < NVEC; i++) begin
      cpuWrite(TBL[i].sel, TBL[i].data);
      readSel(TBL[i].rdSel, rv);
      chk($sformatf("R2/R3/R10 vec%0d read", i), rv, TBL[i].expRd);
      chk($sformatf("R2/R3/R10 vec%0d pend", i), {28'd0, pending}, {28'd0, TBL[i].expPend});
    end

    // Full four-word burst with unaligned start (R4 R5 R6 R8)
    startOp(32'h0000_1003, 2'd3);
    chk("R4 busy", {31'd0, busy}, 32'd1);
    chk("R4 addr", curAddr, 32'h0000_1000);
    serve(32'h1000, 32'h3333_4444, 1'b0, "R5 w0");
    chk("R6 pend", {28'd0, pending}, 32'b1110);
    chk("R6 addr", curAddr, 32'h1004);
    serve(32'h1004, 32'h7777_8888, 1'b0, "R6 w1");
    serve(32'h1008, 32'h9999_AAAA, 1'b0, "R6 w2");
    serve(32'h100C, 32'h5555_6666, 1'b0, "R8 w3");
    chk("R8 busy", {31'd0, busy}, 32'd0);
    chk("R8 addr", curAddr, 32'h100C);
    chk("R8 pend", {28'd0, pending}, 32'd0);

    // Stall on an empty slot (R7)
    cpuWrite(3'd0, 32'hA0A0_A0A0);
    startOp(32'h0000_2000, 2'd1);
    serve(32'h2000, 32'hA0A0_A0A0, 1'b0, "R7 w0");
    for (int k = 0; k < 3; k++) begin
      chk("R7 stall req", {31'd0, flashReq}, 32'd0);
      chk("R7 stall busy", {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
    chk("R7 stall addr", curAddr, 32'h2004);
    cpuWrite(3'd1, 32'hB1B1_B1B1);
    chk("R7 resume req", {31'd0, flashReq}, 32'd1);
    serve(32'h2004, 32'hB1B1_B1B1, 1'b0, "R7 w1");
    chk("R8 stall end busy", {31'd0, busy}, 32'd0);
    chk("R8 stall end addr", curAddr, 32'h2004);

    // Error abort (R9)
    cpuWrite(3'd0, 32'hC0C0_C0C0);
    cpuWrite(3'd1, 32'hC1C1_C1C1);
    cpuWrite(3'd2, 32'hC2C2_C2C2);
    startOp(32'h0000_3000, 2'd2);
    serve(32'h3000, 32'hC0C0_C0C0, 1'b0, "R9 w0");
    serve(32'h3004, 32'hC1C1_C1C1, 1'b1, "R9 w1");
    chk("R9 fail", {31'd0, fail}, 32'd1);
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 pend", {28'd0, pending}, 32'b0110);
    chk("R9 addr", curAddr, 32'h3004);
    chk("R9 req", {31'd0, flashReq}, 32'd0);

    // Restart clears fail, start while busy ignored (R11)
    cpuWrite(3'd0, 32'hD0D0_D0D0);
    startOp(32'h0000_4000, 2'd0);
    chk("R11 fail cleared", {31'd0, fail}, 32'd0);
    chk("R11 busy", {31'd0, busy}, 32'd1);
    chk("R11 addr", curAddr, 32'h4000);
    startOp(32'h0000_5000, 2'd3);
    chk("R11 ignored addr", curAddr, 32'h4000);
    chk("R11 ignored busy", {31'd0, busy}, 32'd1);
    chk("R11 ignored data", flashData, 32'hD0D0_D0D0);

    // Write coincident with acceptance (R12)
    chk("R12 req", {31'd0, flashReq}, 32'd1);
    flashAck = 1'b1;
    regWrEn = 1'b1; regWrSel = 3'd0; regWrData = 32'hE0E0_E0E0;
    @(negedge clk);
    flashAck = 1'b0; regWrEn = 1'b0;
    chk("R12 busy", {31'd0, busy}, 32'd0);
    chk("R12 pend", {28'd0, pending}, 32'b0111);
    readSel(3'd0, rv);
    chk("R12 data", rv, 32'hE0E0_E0E0);
    readSel(3'd4, rv);
    chk("R3 alias after R12", rv, 32'hE0E0_E0E0);
    chk("R8 addr hold", curAddr, 32'h4000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule